// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read-data path of a paged non-volatile memory. While an internal write is in progress, it replaces the array data on the read bus with a status word. A host can learn that the write has finished in two ways. It can watch the top data bit, which shows the inverse of the top bit of the last byte written until the write ends. It can also watch bit 6, which changes value on every read for as long as the write is running.

The write sequencer supplies the busy flag and the last byte written. The bus front end supplies a one-cycle read strobe for each new read access, made by a new edge of the output enable, the chip enable or both. The array supplies its read data. When busy is low, array data reaches the read bus combinationally, with no added latency. Polling by either method may start at any point in the write cycle.

Top module: `write_poll_status`

## Requirements
- R1: While busy_i is high, rd_data_o[7] equals the inverse of last_wr_i[7], in the same cycle.
- R2: While busy_i is high, rd_data_o[6] inverts after each clock edge at which rd_strobe_i and busy_i were both high, so successive reads alternate between 1 and 0.
- R3: While busy_i stays high, a clock edge with rd_strobe_i low leaves rd_data_o[6] unchanged.
- R4: In the first cycle of every write (busy_i high after a low cycle or after reset), rd_data_o[6] is 0. A read strobe in that cycle makes the next cycle show 1.
- R5: While busy_i is high, rd_data_o[5:0] equal last_wr_i[5:0], and track last_wr_i combinationally if it changes.
- R6: While busy_i is low, rd_data_o equals array_i on all eight bits in the same cycle. Bit 6 of last_wr_i never reaches the bus.
- R7: Read strobes while busy_i is low have no effect: the next write still starts with bit 6 at 0.
- R8: While rst_n is low, the toggle state is held at 0 and a low busy_i passes array_i to rd_data_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write in progress; must fall for at least one cycle between writes |
| rd_strobe_i | input | 1 | One-cycle pulse marking a new read access |
| last_wr_i | input | 8 | Last data byte loaded into the write |
| array_i | input | 8 | Data read from the memory array |
| rd_data_o | output | 8 | Value presented on the read bus |

## Verification
The hardest situation to reach is a write that begins while the toggle bit of the previous write was left at 1, together with a read strobe in the very first busy cycle. Only then does a missing clear, or a wrong choice between clear and flip, show on the bus. The stimulus table ends one write with bit 6 at 1, drops busy for a single cycle while strobing, and starts the next write with a strobe in its first cycle. A directed run of back-to-back strobes then checks the alternation on every consecutive read.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic {
    VIEW_ARRAY  = 1'b0,
    VIEW_STATUS = 1'b1
  } view_e;

  function automatic view_e pick_view(input logic busy);
    return busy ? VIEW_STATUS : VIEW_ARRAY;
  endfunction
endpackage

// File: rtl/wps_toggle_track.sv
module wps_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_strobe_i,
  output logic tog_o,
  output logic step_o
);
  logic tog_q;

  function automatic logic next_tog(input logic busy, input logic step, input logic cur);
    if (!busy) return 1'b0;
    return step ? ~cur : cur;
  endfunction

  assign step_o = busy_i & rd_strobe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= next_tog(busy_i, step_o, tog_q);
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/wps_status_word.sv
module wps_status_word #(
  parameter int W        = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic [W-1:0] last_i,
  input  logic         tog_i,
  output logic [W-1:0] word_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word_o[i] = ~last_i[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign word_o[i] = tog_i;
    end else begin : g_copy
      assign word_o[i] = last_i[i];
    end
  end
endmodule

// File: rtl/wps_read_select.sv
module wps_read_select #(
  parameter int W = 8
) (
  input  wps_pkg::view_e view_i,
  input  logic [W-1:0]   array_i,
  input  logic [W-1:0]   status_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    unique case (view_i)
      wps_pkg::VIEW_STATUS: data_o = status_i;
      default:              data_o = array_i;
    endcase
  end
endmodule

// File: rtl/write_poll_status.sv
module write_poll_status #(
  parameter int W        = 8,
  parameter int POLL_BIT = W - 1,
  parameter int TOG_BIT  = W - 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         rd_strobe_i,
  input  logic [W-1:0] last_wr_i,
  input  logic [W-1:0] array_i,
  output logic [W-1:0] rd_data_o
);
  logic           tog;
  logic           tog_step;
  logic [W-1:0]   status_word;
  wps_pkg::view_e view;

  wps_toggle_track u_tog (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .rd_strobe_i (rd_strobe_i),
    .tog_o       (tog),
    .step_o      (tog_step)
  );

  wps_status_word #(.W(W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_word (
    .last_i (last_wr_i),
    .tog_i  (tog),
    .word_o (status_word)
  );

  assign view = wps_pkg::pick_view(busy_i);

  wps_read_select #(.W(W)) u_sel (
    .view_i   (view),
    .array_i  (array_i),
    .status_i (status_word),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int W        = 8,
  parameter int POLL_BIT = W - 1,
  parameter int TOG_BIT  = W - 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_i,
  input logic         rd_strobe_i,
  input logic         tog_step,
  input logic [W-1:0] last_wr_i,
  input logic [W-1:0] array_i,
  input logic [W-1:0] rd_data_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_poll_inverse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> rd_data_o[POLL_BIT] == ~last_wr_i[POLL_BIT]);

  assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy_i && $past(tog_step)) |-> rd_data_o[TOG_BIT] != $past(rd_data_o[TOG_BIT]));

  assert_toggle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy_i && $past(busy_i) && !$past(rd_strobe_i)) |-> $stable(rd_data_o[TOG_BIT]));

  assert_write_starts_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy_i && !$past(busy_i)) |-> rd_data_o[TOG_BIT] == 1'b0);

  assert_idle_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> rd_data_o == array_i);
endmodule

bind write_poll_status wps_checker #(.W(W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_i      (busy_i),
  .rd_strobe_i (rd_strobe_i),
  .tog_step    (tog_step),
  .last_wr_i   (last_wr_i),
  .array_i     (array_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/tb_write_poll_status.sv
module tb_write_poll_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy_i = 1'b0;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] last_wr_i = 8'h00;
  logic [7:0] array_i = 8'h00;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  // {busy, strobe, last, array, expected bus value before this row's edge}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'h5A, 8'h5A},  // R6 idle
    {1'b0, 1'b1, 8'h00, 8'hC3, 8'hC3},  // R7 strobe while idle
    {1'b1, 1'b0, 8'h80, 8'h11, 8'h00},  // R1 R4 first busy cycle
    {1'b1, 1'b1, 8'h80, 8'h11, 8'h00},  // R2 strobe
    {1'b1, 1'b1, 8'h80, 8'h22, 8'h40},  // R2
    {1'b1, 1'b0, 8'h80, 8'h33, 8'h00},  // R2 R3
    {1'b1, 1'b1, 8'h80, 8'h33, 8'h00},  // R3
    {1'b1, 1'b0, 8'h80, 8'h44, 8'h40},  // R2
    {1'b0, 1'b0, 8'h80, 8'h77, 8'h77},  // R6
    {1'b1, 1'b0, 8'h3F, 8'h99, 8'hBF},  // R1 R4 R5
    {1'b1, 1'b1, 8'h3F, 8'h99, 8'hBF},  // R2
    {1'b1, 1'b0, 8'h3F, 8'h99, 8'hFF},  // R2
    {1'b0, 1'b1, 8'h3F, 8'hA5, 8'hA5},  // R7 gap of one cycle with strobe
    {1'b1, 1'b1, 8'h00, 8'hA5, 8'h80},  // R4 strobe in first busy cycle
    {1'b1, 1'b0, 8'h00, 8'hA5, 8'hC0},  // R4 shows 1 next
    {1'b1, 1'b0, 8'h7F, 8'h00, 8'hFF},  // R5 last changes mid-write
    {1'b1, 1'b0, 8'hC1, 8'h00, 8'h41},  // R1 R5
    {1'b0, 1'b0, 8'h00, 8'hE6, 8'hE6},  // R6
    {1'b0, 1'b1, 8'hFF, 8'h40, 8'h40},  // R6 last bit 6 not seen
    {1'b1, 1'b0, 8'hFF, 8'h00, 8'h3F}   // R4 R7
  };

  write_poll_status dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .rd_strobe_i (rd_strobe_i),
    .last_wr_i   (last_wr_i),
    .array_i     (array_i),
    .rd_data_o   (rd_data_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic exp_tog;
    // R8 reset state
    busy_i = 1'b0; array_i = 8'h3C;
    repeat (3) @(negedge clk);
    #1 check("R8 reset passthrough", rd_data_o, 8'h3C);
    busy_i = 1'b1; rd_strobe_i = 1'b1; last_wr_i = 8'h00;
    @(negedge clk);
    #1 check("R8 toggle held in reset", rd_data_o, 8'h80);
    busy_i = 1'b0; rd_strobe_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      busy_i      = VEC[i][25];
      rd_strobe_i = VEC[i][24];
      last_wr_i   = VEC[i][23:16];
      array_i     = VEC[i][15:8];
      #1 check($sformatf("R1-R7 vector %0d", i), rd_data_o, VEC[i][7:0]);
      @(negedge clk);
    end

    // R2 back-to-back strobes: alternation on every read
    busy_i = 1'b0; rd_strobe_i = 1'b0;
    @(negedge clk);
    busy_i = 1'b1; last_wr_i = 8'h55; rd_strobe_i = 1'b1;
    exp_tog = 1'b0;
    for (int k = 0; k < 9; k++) begin
      #1 check("R2 back-to-back toggle", rd_data_o, {1'b1, exp_tog, 6'h15});
      @(negedge clk);
      exp_tog = ~exp_tog;
    end
    // R3 hold without strobe
    rd_strobe_i = 1'b0;
    repeat (3) begin
      #1 check("R3 no strobe holds", rd_data_o, {1'b1, exp_tog, 6'h15});
      @(negedge clk);
    end
    // R6 completion returns true data immediately
    busy_i = 1'b0; array_i = 8'h9E;
    #1 check("R6 true data after write", rd_data_o, 8'h9E);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule